// File: doc/BRIEF.md
# Stop Mode Wake-Up Controller

This block controls entry into and exit from a low-power stop state in a small microcontroller. When the core issues a stop command, the block drops its oscillator-enable output. This removes the clock from the block and from the core, and it drops the run output so that the core holds. With no clock running, the block still watches an active-low external interrupt pin and a small input port. Each port pin can wake the device, but only if its bit is set in a write-only wake-enable register. A low level on the external pin wakes the device unconditionally.

When a wake condition occurs, asynchronous logic raises the oscillator enable at once. Once the clock returns, the block counts a warm-up interval of a parameterised number of oscillator cycles. It then raises the run output, and the core continues with the instruction that follows the stop command. If the external pin is already low when the stop command arrives, the block skips the stopped state and goes straight into warm-up.

Top module: `stopwake_ctrl`

## Requirements
- R1: After reset, run_o and osc_en are both 1 and every wake-enable bit is 0.
- R2: A stop_cmd pulse while running with ext_int_n high drops run_o and osc_en after that clock edge, and no further clock edges follow.
- R3: While stopped, a low level on ext_int_n raises osc_en without any clock edge, whatever the wake-enable bits hold.
- R4: While stopped, a falling edge on port_i[n] raises osc_en without any clock edge when wake-enable bit n is 1.
- R5: While stopped, a falling edge on port_i[n] whose wake-enable bit n is 0 leaves osc_en at 0.
- R6: Rising edges on the port while stopped, and falling edges on the port while running, never cause a wake.
- R7: After a wake, run_o stays 0 for exactly WARM+1 clock edges, counting the first edge after the clock resumes, and rises on the last of them. osc_en stays 1 from the wake onward.
- R8: A stop_cmd while ext_int_n is low goes straight to warm-up. osc_en never drops, and run_o rises on the (WARM+1)-th edge, counting the command edge.
- R9: A pulse on wen_we loads wen_d into the wake-enable register with bit n enabling port_i[n]. A later write fully replaces the earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; it stops whenever osc_en is low |
| rst | input | 1 | Synchronous active-high reset |
| stop_cmd | input | 1 | One-cycle stop request from the core |
| wen_we | input | 1 | Write strobe for the wake-enable register |
| wen_d | input | PINS | Value written into the wake-enable register |
| ext_int_n | input | 1 | External interrupt pin, active low |
| port_i | input | PINS | Input port pins watched for falling edges |
| osc_en | output | 1 | Oscillator enable |
| run_o | output | 1 | High when the core may execute |

## Verification
The assertions assume that stop_cmd and wen_we are sampled only on edges of the block's own clock, which is the gated oscillator. They also assume that no reset arrives while the clock is stopped, because a synchronous reset cannot act in that state. The bench builds the block's clock from a free-running source through a glitch-free latch gate controlled by osc_en. It changes stop_cmd and the register inputs only at falling edges of that source while the clock runs, and it toggles the port and external pin only during the stopped state or well away from any stop request.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;
  typedef enum logic [1:0] {
    SW_RUN    = 2'd0,
    SW_STOP   = 2'd1,
    SW_WARMUP = 2'd2
  } sw_state_e;
endpackage

// File: rtl/stopwake_edge_catch.sv
module stopwake_edge_catch (
  input  logic pin,
  input  logic clr,
  output logic hit
);
  // Captures a falling edge with no clock; held clear whenever not stopped.
  always_ff @(negedge pin or posedge clr) begin
    if (clr) hit <= 1'b0;
    else     hit <= 1'b1;
  end
endmodule

// File: rtl/stopwake_wake_detect.sv
module stopwake_wake_detect #(
  parameter int PINS = 4
) (
  input  logic            armed,
  input  logic            ext_int_n,
  input  logic [PINS-1:0] port_i,
  input  logic [PINS-1:0] wen,
  output logic            wake_raw
);
  logic [PINS-1:0] hit;

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    stopwake_edge_catch u_catch (
      .pin (port_i[n]),
      .clr (~armed),
      .hit (hit[n])
    );
  end

  assign wake_raw = armed & (~ext_int_n | (|(hit & wen)));
endmodule

// File: rtl/stopwake_warmup.sv
module stopwake_warmup #(
  parameter int WARM = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic done
);
  localparam int CW = (WARM > 1) ? $clog2(WARM) : 1;
  localparam logic [CW-1:0] LAST = CW'(WARM - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active) cnt <= '0;
    else if (!done)     cnt <= cnt + 1'b1;
  end

  assign done = active && (cnt == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);                                                   // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (active && !done) |=> (cnt == $past(cnt) + 1'b1));              // R7
endmodule

// File: rtl/stopwake_ctrl.sv
module stopwake_ctrl
  import stopwake_pkg::*;
#(
  parameter int PINS = 4,
  parameter int WARM = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stop_cmd,
  input  logic            wen_we,
  input  logic [PINS-1:0] wen_d,
  input  logic            ext_int_n,
  input  logic [PINS-1:0] port_i,
  output logic            osc_en,
  output logic            run_o
);
  sw_state_e       st, st_n;
  logic [PINS-1:0] wen;
  logic            run_q;
  logic            wake_raw;
  logic            wake_pend;
  logic            warm_done;
  logic            in_stop;

  assign in_stop = (st == SW_STOP);

  // Write-only wake-enable register
  always_ff @(posedge clk) begin
    if (rst)         wen <= '0;
    else if (wen_we) wen <= wen_d;
  end

  stopwake_wake_detect #(.PINS(PINS)) u_detect (
    .armed     (in_stop),
    .ext_int_n (ext_int_n),
    .port_i    (port_i),
    .wen       (wen),
    .wake_raw  (wake_raw)
  );

  // Wake request held asynchronously until the clock has resumed
  always_ff @(posedge clk or posedge wake_raw) begin
    if (wake_raw)              wake_pend <= 1'b1;
    else if (rst)              wake_pend <= 1'b0;
    else if (st == SW_WARMUP)  wake_pend <= 1'b0;
  end

  stopwake_warmup #(.WARM(WARM)) u_warm (
    .clk    (clk),
    .rst    (rst),
    .active (st == SW_WARMUP),
    .done   (warm_done)
  );

  always_comb begin
    st_n = st;
    unique case (st)
      SW_RUN:    if (stop_cmd)  st_n = ext_int_n ? SW_STOP : SW_WARMUP;
      SW_STOP:   if (wake_pend) st_n = SW_WARMUP;
      SW_WARMUP: if (warm_done) st_n = SW_RUN;
      default:   st_n = SW_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SW_RUN;
      run_q <= 1'b1;
    end else begin
      st    <= st_n;
      run_q <= (st_n == SW_RUN);
    end
  end

  assign run_o  = run_q;
  assign osc_en = ~in_stop | wake_pend;

  AST_RUN_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
    run_o |-> osc_en);                                              // R7
  AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (run_q && stop_cmd && ext_int_n) |=> (!run_o && in_stop));      // R2
  AST_DIRECT_WARM: assert property (@(posedge clk) disable iff (rst)
    (run_q && stop_cmd && !ext_int_n) |=> (st == SW_WARMUP && osc_en)); // R8
  AST_WARM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == SW_WARMUP && !warm_done) |=> !run_o);                    // R7
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (st == SW_WARMUP) |=> !wake_pend);                              // R3
  AST_WEN_LOAD: assert property (@(posedge clk) disable iff (rst)
    wen_we |=> (wen == $past(wen_d)));                              // R9
endmodule

// File: tb/stopwake_ctrl_tb.sv
module stopwake_ctrl_tb;
  localparam int PINS = 4;
  localparam int WARM = 16;

  logic            sys_clk = 1'b0;
  logic            gate = 1'b1;
  logic            dut_clk;
  logic            rst = 1'b1;
  logic            stop_cmd = 1'b0;
  logic            wen_we = 1'b0;
  logic [PINS-1:0] wen_d = '0;
  logic            ext_int_n = 1'b1;
  logic [PINS-1:0] port_i = '1;
  logic            osc_en;
  logic            run_o;

  int checks = 0;
  int errors = 0;

  always #2.5 sys_clk = ~sys_clk;

  // Glitch-free clock gate: the enable passes only while the source is low
  always @(sys_clk or osc_en) if (!sys_clk) gate = osc_en;
  assign dut_clk = sys_clk & gate;

  stopwake_ctrl #(.PINS(PINS), .WARM(WARM)) u_dut (
    .clk(dut_clk), .rst(rst), .stop_cmd(stop_cmd), .wen_we(wen_we),
    .wen_d(wen_d), .ext_int_n(ext_int_n), .port_i(port_i),
    .osc_en(osc_en), .run_o(run_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_wen(input logic [PINS-1:0] v);
    @(negedge sys_clk); wen_we = 1'b1; wen_d = v;
    @(negedge sys_clk); wen_we = 1'b0;
  endtask

  task automatic enter_stop();
    @(negedge sys_clk); stop_cmd = 1'b1;
    @(negedge sys_clk); stop_cmd = 1'b0;
    #20;
  endtask

  // Counts edges of the gated clock until run_o rises
  task automatic count_to_run(output int n);
    n = 0;
    for (int i = 0; i < 4 * WARM + 8; i++) begin
      @(posedge dut_clk); n++;
      #1;
      if (run_o) break;
    end
  endtask

  task automatic t_reset();
    chk("R1 run after reset", run_o, 1);
    chk("R1 osc after reset", osc_en, 1);
    enter_stop();
    port_i = 4'b0000; #10;
    chk("R1 wake enables cleared", osc_en, 0);
    ext_int_n = 1'b0; #3;
    ext_int_n = 1'b1;
    begin int n; count_to_run(n); end
    port_i = '1; #10;
  endtask

  task automatic t_stop_ext();
    int n;
    int edges = 0;
    write_wen(4'b0000);
    enter_stop();
    chk("R2 run low in stop", run_o, 0);
    chk("R2 osc low in stop", osc_en, 0);
    fork
      begin repeat (4) @(posedge dut_clk); end
      begin #40; end
    join_any
    disable fork;
    edges = (osc_en == 1'b0) ? 0 : 1;
    chk("R2 clock held stopped", edges, 0);
    ext_int_n = 1'b0; #1;
    chk("R3 ext low wakes osc", osc_en, 1);
    chk("R7 run still low at wake", run_o, 0);
    count_to_run(n);
    chk("R7 warm-up edge count", n, WARM + 1);
    chk("R7 osc stays on", osc_en, 1);
    ext_int_n = 1'b1; #10;
  endtask

  task automatic t_port_wake(input int pin);
    int n;
    write_wen(4'(1 << pin));
    enter_stop();
    chk("R4 stopped before edge", osc_en, 0);
    port_i[pin] = 1'b0; #1;
    chk("R4 enabled falling edge wakes", osc_en, 1);
    count_to_run(n);
    chk("R7 warm-up after port wake", n, WARM + 1);
    port_i[pin] = 1'b1; #10;
  endtask

  task automatic t_masked();
    int n;
    write_wen(4'b0001);
    port_i[0] = 1'b0; #10;                 // falls while running
    enter_stop();
    chk("R6 run-time edge not kept", osc_en, 0);
    port_i[2] = 1'b0; #10;
    chk("R5 disabled pin ignored", osc_en, 0);
    port_i[0] = 1'b1; #10;
    chk("R6 rising edge ignored", osc_en, 0);
    ext_int_n = 1'b0; #1;
    chk("R3 ext wakes despite mask", osc_en, 1);
    count_to_run(n);
    ext_int_n = 1'b1; port_i = '1; #10;
  endtask

  task automatic t_direct();
    int n;
    int dropped = 0;
    ext_int_n = 1'b0;
    @(negedge sys_clk); stop_cmd = 1'b1;
    n = 0;
    @(posedge dut_clk); n++;
    @(negedge sys_clk); stop_cmd = 1'b0;
    chk("R8 run low after command", run_o, 0);
    for (int i = 0; i < 4 * WARM; i++) begin
      if (!osc_en) dropped = 1;
      if (run_o) break;
      @(posedge dut_clk); n++;
      #1;
    end
    chk("R8 osc never dropped", dropped, 0);
    chk("R8 edges to run", n, WARM + 1);
    ext_int_n = 1'b1; #10;
  endtask

  task automatic t_rewrite();
    int n;
    write_wen(4'b0001);
    write_wen(4'b0100);
    enter_stop();
    port_i[0] = 1'b0; #10;
    chk("R9 old enable replaced", osc_en, 0);
    port_i[2] = 1'b0; #1;
    chk("R9 new enable active", osc_en, 1);
    count_to_run(n);
    chk("R9 warm-up completes", n, WARM + 1);
    port_i = '1; #10;
  endtask

  initial begin
    repeat (4) @(negedge sys_clk);
    rst = 1'b0;
    @(negedge sys_clk);
    t_reset();
    t_stop_ext();
    t_port_wake(0);
    t_port_wake(3);
    t_masked();
    t_direct();
    t_rewrite();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule